// File: doc/BRIEF.md
# Successive-Approximation Core with Two-Order Result Serializer

This block runs the digital half of an 8-bit successive-approximation conversion. It drives a trial code to an external DAC and reads back one comparator decision per cycle. It settles one result bit per cycle, starting at the most significant bit. Each decision goes straight to the serial output on the next cycle, so a host reads the result most significant bit first while the conversion is still running.

When the last bit is settled, the finished word is copied in parallel into a shift register. The serial output can then send the word a second time, least significant bit first, under the control of the `msb_only` input. The least significant bit is shared: it closes the first stream and opens the second, so the replay carries only bits 1 and up. The start pulse comes from a command sequencer. Chip select (`sel_n`, active low) frames each conversion, and raising it aborts the frame.

Top module: `sar_core`

## Requirements
- R1: While `sel_n` is high, `ser_oe` is low. A clock edge that samples `sel_n` high returns the block to idle: `busy` is 0 and `ser_out` is 0 on the next cycle. `conv_start` is ignored while `sel_n` is high. After a frame has ended, `conv_start` is ignored until `sel_n` has been high for at least one edge.
- R2: An edge that samples `conv_start` high with `sel_n` low in idle starts a conversion. On the next cycle `busy` is 1, `ser_oe` is 1, `ser_out` is 0 (a leading zero), and `trial_code` has only its MSB set (0x80).
- R3: Each conversion edge keeps the bit under trial when `cmp_hi` is 1 (input at or above the trial code) and clears it when `cmp_hi` is 0. The same edge sets the next lower bit, so the trial code seen before deciding bit k is the settled upper bits with bit k set.
- R4: In the cycle after each conversion edge, `ser_out` equals the `cmp_hi` value sampled at that edge. Bits therefore appear in order from bit 7 down to bit 0.
- R5: `busy` stays high for exactly W = 8 cycles. Once it falls, `trial_code` holds the final result, and that result is the input clamped to the range 0..255.
- R6: When the positive input is below the negative input, every decision is 0 and the result is 0x00.
- R7: If `msb_only` is high at the last conversion edge, no replay follows. `ser_out` holds bit 0 for as long as `msb_only` stays high.
- R8: If `msb_only` is low at the last conversion edge, bits 1 through 7 follow bit 0 on the next seven cycles, one per cycle, in ascending order. Bit 0 is not sent again.
- R9: If `msb_only` is high at the last conversion edge and falls later, the first edge that samples it low changes nothing on `ser_out`. Bits 1 through 7 then appear on the following seven edges.
- R10: After the replay, or after bit 7 in the case of R9, `ser_out` stays 0 with `ser_oe` high until `sel_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one bit period per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low; high aborts and clears the frame |
| conv_start | input | 1 | Start request from the command sequencer |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above `trial_code` |
| msb_only | input | 1 | High suppresses the LSB-first replay; low enables it |
| trial_code | output | 8 | Trial code for the DAC; holds the result after conversion |
| busy | output | 1 | High while a conversion is in progress |
| ser_out | output | 1 | Serial data |
| ser_oe | output | 1 | Drive enable for `ser_out`; low means high impedance |

## Verification
On every cycle, the assertions check the following:
- the leading zero and the initial trial code on the cycle after a start;
- that the serial bit matches the comparator decision from one cycle earlier;
- the exact length of the `busy` window, using a counter;
- that the output is stable while a replay is held back, low after the frame ends, and cleared after a deselect.

Only the bench's scenarios can show the rest. They show that the bit streams match an ideal clamped quantizer across the whole input range, including inputs above full scale and negative differences. They also show the order and one-cycle placement of the replay bits for each `msb_only` timing, and that start pulses are ignored after a frame or during deselect.

// File: rtl/sar_core_pkg.sv
package sar_core_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CONV,
    S_HOLD,
    S_REPLAY,
    S_DONE
  } sar_state_t;
endpackage

// File: rtl/sar_core_seq.sv
module sar_core_seq
  import sar_core_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_n,
  input  logic       conv_start,
  input  logic       msb_only,
  output sar_state_t st,
  output logic       init,
  output logic       conv_step,
  output logic       eoc,
  output logic       replay_step,
  output logic       done,
  output logic       busy
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CONV_LAST = CW'(W - 1);
  localparam logic [CW-1:0] REPLAY_LAST = CW'(W - 2);

  sar_state_t st_q;
  logic [CW-1:0] cnt_q;
  logic busy_q;

  assign st          = st_q;
  assign init        = (st_q == S_IDLE) && conv_start && !sel_n;
  assign conv_step   = (st_q == S_CONV);
  assign eoc         = conv_step && (cnt_q == '0);
  assign replay_step = (st_q == S_REPLAY);
  assign done        = (st_q == S_DONE);
  assign busy        = busy_q;

  always_ff @(posedge clk) begin
    if (rst || sel_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          if (conv_start) begin
            st_q   <= S_CONV;
            cnt_q  <= CONV_LAST;
            busy_q <= 1'b1;
          end
        end
        S_CONV: begin
          if (cnt_q == '0) begin
            busy_q <= 1'b0;
            cnt_q  <= REPLAY_LAST;
            st_q   <= msb_only ? S_HOLD : S_REPLAY;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        S_HOLD: begin
          if (!msb_only) st_q <= S_REPLAY;
        end
        S_REPLAY: begin
          if (cnt_q == '0) st_q <= S_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        S_DONE: st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_core_approx.sv
module sar_core_approx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         init,
  input  logic         step,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic [W-1:0] settled
);
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] code_q;
  logic [W-1:0] probe_q;

  // bit under trial kept on a high decision, dropped otherwise
  assign settled = cmp_hi ? code_q : (code_q & ~probe_q);
  assign trial   = code_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code_q  <= '0;
      probe_q <= '0;
    end else if (init) begin
      code_q  <= TOP_BIT;
      probe_q <= TOP_BIT;
    end else if (step) begin
      code_q  <= settled | (probe_q >> 1);
      probe_q <= probe_q >> 1;
    end
  end
endmodule

// File: rtl/sar_core_shift.sv
module sar_core_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         init,
  input  logic         conv_step,
  input  logic         eoc,
  input  logic         replay_step,
  input  logic         done,
  input  logic         cmp_hi,
  input  logic [W-1:0] settled,
  output logic         dout,
  output logic         oe
);
  logic [W-1:0] sh_q;
  logic         dout_q;
  logic         oe_q;

  assign dout = dout_q;
  assign oe   = oe_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sh_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (init) begin
        oe_q   <= 1'b1;
        dout_q <= 1'b0;
      end else if (conv_step) begin
        dout_q <= cmp_hi;
        if (eoc) sh_q <= settled;
      end else if (replay_step) begin
        dout_q <= sh_q[1];
        sh_q   <= sh_q >> 1;
      end else if (done) begin
        dout_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_core_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel_n,
  input  logic         conv_start,
  input  logic         cmp_hi,
  input  logic         msb_only,
  output logic [W-1:0] trial_code,
  output logic         busy,
  output logic         ser_out,
  output logic         ser_oe
);
  sar_state_t   st;
  logic         init, conv_step, eoc, replay_step, done;
  logic [W-1:0] settled;
  logic         oe_q;

  sar_core_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .sel_n(sel_n), .conv_start(conv_start),
    .msb_only(msb_only), .st(st), .init(init), .conv_step(conv_step),
    .eoc(eoc), .replay_step(replay_step), .done(done), .busy(busy)
  );

  sar_core_approx #(.W(W)) u_approx (
    .clk(clk), .rst(rst), .clr(sel_n), .init(init), .step(conv_step),
    .cmp_hi(cmp_hi), .trial(trial_code), .settled(settled)
  );

  sar_core_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .clr(sel_n), .init(init), .conv_step(conv_step),
    .eoc(eoc), .replay_step(replay_step), .done(done), .cmp_hi(cmp_hi),
    .settled(settled), .dout(ser_out), .oe(oe_q)
  );

  assign ser_oe = oe_q && !sel_n;
endmodule

// File: rtl/sar_core_chk.sv
module sar_core_chk
  import sar_core_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         sel_n,
  input logic         cmp_hi,
  input logic [W-1:0] trial_code,
  input logic         busy,
  input logic         ser_out,
  input logic         ser_oe,
  input sar_state_t   st
);
  localparam int BW = $clog2(W + 1) + 1;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= '0;
    else bcnt <= bcnt + 1'b1;
  end

  AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(sel_n) |-> (!busy && !ser_out && st == S_IDLE)); // R1

  AST_START_STATE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!ser_out && ser_oe && trial_code == TOP_BIT)); // R2

  AST_TRIAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($countones(trial_code ^ $past(trial_code)) <= 2)); // R3

  AST_LIVE_BIT: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (ser_out == $past(cmp_hi))); // R4

  AST_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(sel_n)) |-> (ser_out == $past(cmp_hi))); // R4

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < BW'(W))); // R5

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(sel_n)) |-> (bcnt == BW'(W))); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && $past(st) == S_HOLD) |-> $stable(ser_out)); // R7

  AST_DONE_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE && $past(st) == S_DONE) |-> !ser_out); // R10
endmodule

bind sar_core sar_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .cmp_hi(cmp_hi),
  .trial_code(trial_code), .busy(busy), .ser_out(ser_out),
  .ser_oe(ser_oe), .st(st)
);

// File: tb/sar_core_tb.sv
`timescale 1ns/1ps
module sar_core_tb;
  localparam int W = 8;
  localparam int FULL = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic conv_start = 1'b0;
  logic msb_only = 1'b1;
  logic [W-1:0] trial_code;
  logic busy, ser_out, ser_oe, cmp_hi;
  int vp = 0;
  int vn = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  // ideal comparator on the difference of the two inputs
  assign cmp_hi = ((vp - vn) >= 0) && ((vp - vn) >= int'(trial_code));

  sar_core #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .conv_start(conv_start),
    .cmp_hi(cmp_hi), .msb_only(msb_only), .trial_code(trial_code),
    .busy(busy), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int quant(input int d);
    if (d < 0) return 0;
    if (d > FULL) return FULL;
    return d;
  endfunction

  // mode 0: replay enabled at EOC; mode 1: msb_only held high, falls after hold cycles
  task automatic run_conv(input int p, input int n, input int mode, input int hold);
    int res;
    int upper;
    vp = p;
    vn = n;
    res = quant(p - n);
    msb_only = (mode != 0);
    sel_n = 1'b0;
    conv_start = 1'b1;
    tick();
    conv_start = 1'b0;
    chk(busy == 1'b1 && ser_oe == 1'b1, "R2 busy/oe", {busy, ser_oe}, 3);
    chk(ser_out == 1'b0, "R2 leading zero", ser_out, 0);
    chk(trial_code == 8'h80, "R2 initial trial", trial_code, 8'h80);
    for (int k = W - 1; k >= 0; k--) begin
      upper = res & ~((1 << (k + 1)) - 1);
      chk(int'(trial_code) == (upper | (1 << k)), "R3 trial code", trial_code, upper | (1 << k));
      tick();
      chk(ser_out == res[k], "R4 live bit", ser_out, res[k]);
      chk(busy == (k != 0), "R5 busy window", busy, k != 0);
    end
    chk(int'(trial_code) == res, (p < n) ? "R6 negative result" : "R5 result", trial_code, res);
    if (mode != 0) begin
      for (int h = 0; h < hold; h++) begin
        tick();
        chk(ser_out == res[0], "R7 hold lsb", ser_out, res[0]);
      end
      msb_only = 1'b0;
      tick();
      chk(ser_out == res[0], "R9 first low edge", ser_out, res[0]);
    end
    for (int i = 1; i < W; i++) begin
      tick();
      chk(ser_out == res[i], (mode != 0) ? "R9 late replay" : "R8 replay", ser_out, res[i]);
    end
    conv_start = 1'b1;
    for (int j = 0; j < 2; j++) begin
      tick();
      chk(ser_out == 1'b0 && ser_oe == 1'b1, "R10 low after frame", {ser_out, ser_oe}, 1);
      chk(busy == 1'b0, "R1 start ignored after frame", busy, 0);
    end
    conv_start = 1'b0;
    sel_n = 1'b1;
    tick();
    chk(ser_oe == 1'b0 && busy == 1'b0, "R1 deselect", {ser_oe, busy}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk(busy == 1'b0 && ser_oe == 1'b0 && ser_out == 1'b0, "R1 reset state",
        {busy, ser_oe, ser_out}, 0);
    chk(trial_code == '0, "R1 reset trial", trial_code, 0);

    // start while deselected is ignored
    conv_start = 1'b1;
    repeat (2) tick();
    chk(busy == 1'b0 && ser_oe == 1'b0, "R1 start while deselected", {busy, ser_oe}, 0);
    conv_start = 1'b0;

    // full input sweep with immediate replay, beyond full scale included
    for (int v = 0; v < 300; v++) run_conv(v, 0, 0, 0);

    // replay held back, falling after a varying number of cycles
    for (int v = 0; v <= FULL; v++) run_conv(v + 40, 40, 1, v % 5);

    // negative differences give all zeros
    for (int d = 1; d < 60; d += 7) run_conv(20, 20 + d, d % 2, 1);

    // abort in the middle of a conversion
    vp = 200;
    vn = 0;
    msb_only = 1'b0;
    sel_n = 1'b0;
    conv_start = 1'b1;
    tick();
    conv_start = 1'b0;
    repeat (3) tick();
    sel_n = 1'b1;
    tick();
    chk(busy == 1'b0 && ser_oe == 1'b0 && ser_out == 1'b0, "R1 abort clears",
        {busy, ser_oe, ser_out}, 0);
    sel_n = 1'b0;
    repeat (3) tick();
    chk(busy == 1'b0 && ser_oe == 1'b0, "R1 no restart without start", {busy, ser_oe}, 0);
    sel_n = 1'b1;
    tick();
    run_conv(200, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule